// File: doc/BRIEF.md
# Display Timing Generator with Frame-Period Limiter

This block produces the horizontal sync, vertical sync and data-enable strobes for a display output, together with a one-clock start-of-frame marker. Every line is laid out as sync pulse, back porch, active pixels and front porch. Every frame is laid out the same way, counted in lines. All sizes, porches and polarities come in on plain configuration pins.

A frame-period budget, given in pixel clocks, sets an exact frame length. When the budget is longer than the nominal frame (line total times line count), the block stretches the horizontal front porch of the last line of the frame. The stretch equals the difference, so every frame lasts exactly the budget. The other lines keep their nominal length. A display therefore sees the intended refresh rate even when the pixel clock can only be set in coarse steps. When the budget is at or below the nominal length, no stretch is applied.

The configuration pins are captured into a shadow copy on the first clock after reset and again at every frame boundary. A change on the pins therefore never alters a frame already in progress. Before the first capture, the shadow holds a built-in default set: 1280x640 active area, horizontal sync/back/front 40/50/50 pixels, vertical sync/back/front 20/31/30 lines, both syncs active low, data enable active high, and a budget of one sixtieth of a second at the default 61.15 MHz pixel clock. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. Pixel data and the pixel clock are supplied elsewhere.

Top module: `vtg_limiter_top`

## Requirements
- R1: While reset is held, and until the first frame starts, the outputs sit idle at the default polarity: sync_h_o=1, sync_v_o=0 is never driven, so sync_v_o=1, de_o=0 and sof_o=0.
- R2: Each line is sync, back porch, active and front porch in that order. The horizontal sync is asserted for the programmed sync width in pixels on every line. The data enable is asserted for exactly the active width in consecutive clocks. It rises exactly back-porch clocks after the horizontal sync deasserts.
- R3: Each frame is vertical sync, back porch, active and front porch lines in that order. The vertical sync is asserted for sync-width lines, which is sync-width times line-total clocks. Data enable appears on exactly the active-height lines.
- R4: Each of the three strobes has its own polarity pin. Pin value 1 makes the asserted level high and 0 makes it low. Deasserted is the opposite level.
- R5: When the budget exceeds the nominal frame length, the frame period (start-of-frame to start-of-frame) equals the budget exactly.
- R6: When the budget is at or below the nominal frame length, the frame period equals the nominal length. The extension is clamped at zero.
- R7: Only the last line of the frame is lengthened. Its horizontal-sync-to-horizontal-sync interval is the line total plus the extension, and every other line keeps exactly the line total. There is one horizontal sync per line.
- R8: Configuration pins are sampled only at a frame boundary. A change made mid-frame leaves the rest of that frame on the old settings, and the next frame uses the new ones.
- R9: sof_o is a single-clock pulse coincident with the first active pixel of each frame, with de_o asserted in that clock.
- R10: After reset is released, the first start-of-frame pulse appears exactly (vsync+vback)*linetotal + hsync+hback + 2 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_h_sync | input | 12 | Horizontal sync width, pixels (>=1) |
| cfg_h_back | input | 12 | Horizontal back porch, pixels (>=1) |
| cfg_h_act | input | 12 | Active pixels per line (>=1) |
| cfg_h_front | input | 12 | Horizontal front porch, pixels (>=1) |
| cfg_v_sync | input | 12 | Vertical sync width, lines (>=1) |
| cfg_v_back | input | 12 | Vertical back porch, lines (>=1) |
| cfg_v_act | input | 12 | Active lines per frame (>=1) |
| cfg_v_front | input | 12 | Vertical front porch, lines (>=1) |
| cfg_hs_pol | input | 1 | Horizontal sync asserted level (1 high, 0 low) |
| cfg_vs_pol | input | 1 | Vertical sync asserted level (1 high, 0 low) |
| cfg_de_pol | input | 1 | Data-enable asserted level (1 high, 0 low) |
| cfg_budget | input | 32 | Target frame period in pixel clocks |
| sync_h_o | output | 1 | Horizontal sync |
| sync_v_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| sof_o | output | 1 | Start-of-frame pulse on the first active pixel |

## Verification
Each strobe trails the counter position that produces it by one register, and counting starts one clock after reset release. So a raster position p appears at the outputs p+2 clocks after release, and the first start-of-frame is due at its offset plus two. Most checks measure intervals between output events sampled on the falling edge: periods, pulse widths, sync-to-enable gaps and line spacing. That fixed latency cancels out of them. The two checks tied to absolute timing are the reset-release test and the mid-frame reconfiguration test. The first counts falling edges from release to the first pulse. The second predicts the mixed interval as the old frame's tail plus the new frame's start offset.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int HW  = 12;           // width of every horizontal field
  localparam int VW  = 12;           // width of every vertical field
  localparam int BW  = 32;           // frame budget / horizontal counter width
  localparam int LW  = HW + 2;       // line total (sum of four fields)
  localparam int VTW = VW + 2;       // frame line total
  localparam int NW  = LW + VTW;     // nominal frame length product

  typedef struct packed {
    logic [HW-1:0] h_sync;
    logic [HW-1:0] h_back;
    logic [HW-1:0] h_act;
    logic [HW-1:0] h_front;
    logic [VW-1:0] v_sync;
    logic [VW-1:0] v_back;
    logic [VW-1:0] v_act;
    logic [VW-1:0] v_front;
    logic          hs_pol;
    logic          vs_pol;
    logic          de_pol;
    logic [BW-1:0] budget;
  } tmg_cfg_t;

  localparam tmg_cfg_t CFG_DEFAULT = '{
    h_sync:  HW'(40),
    h_back:  HW'(50),
    h_act:   HW'(1280),
    h_front: HW'(50),
    v_sync:  VW'(20),
    v_back:  VW'(31),
    v_act:   VW'(640),
    v_front: VW'(30),
    hs_pol:  1'b0,
    vs_pol:  1'b0,
    de_pol:  1'b1,
    budget:  BW'(1019167)
  };
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  tmg_cfg_t       cfg_d,
  output tmg_cfg_t       cfg_q,
  output logic [LW-1:0]  htot,
  output logic [VTW-1:0] vtot,
  output logic [BW-1:0]  ext
);
  logic [NW-1:0] nominal;

  always_comb begin
    htot    = LW'(cfg_q.h_sync) + LW'(cfg_q.h_back) + LW'(cfg_q.h_act) + LW'(cfg_q.h_front);
    vtot    = VTW'(cfg_q.v_sync) + VTW'(cfg_q.v_back) + VTW'(cfg_q.v_act) + VTW'(cfg_q.v_front);
    nominal = NW'(htot) * NW'(vtot);
  end

  // The stretch is needed only on the last line, so it is registered one
  // clock after the shadow settles rather than on the capture path.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_DEFAULT;
      ext   <= '0;
    end else begin
      if (load) cfg_q <= cfg_d;
      ext <= (cfg_q.budget > BW'(nominal)) ? (cfg_q.budget - BW'(nominal)) : '0;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  // R6
  ext_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (cfg_q.budget <= BW'(nominal))) |=> (ext == '0));
endmodule

// File: rtl/vtg_scan.sv
module vtg_scan
  import vtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LW-1:0]  htot,
  input  logic [VTW-1:0] vtot,
  input  logic [BW-1:0]  ext,
  output logic           running,
  output logic [BW-1:0]  hpos,
  output logic [VTW-1:0] vpos,
  output logic           load
);
  logic          last_line;
  logic          line_end;
  logic          frame_end;
  logic [BW-1:0] llen;

  always_comb begin
    last_line = (vpos == vtot - VTW'(1));
    llen      = BW'(htot) + (last_line ? ext : '0);
    line_end  = (hpos == llen - BW'(1));
    frame_end = running && line_end && last_line;
    load      = !running || frame_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      hpos    <= '0;
      vpos    <= '0;
    end else if (!running) begin
      running <= 1'b1;
    end else if (line_end) begin
      hpos <= '0;
      vpos <= last_line ? '0 : vpos + VTW'(1);
    end else begin
      hpos <= hpos + BW'(1);
    end
  end

  // R7
  hpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hpos < llen));

  // R3
  vpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (vpos < vtot));

  // R5
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (hpos == '0 && vpos == '0 && running));
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           running,
  input  logic [BW-1:0]  hpos,
  input  logic [VTW-1:0] vpos,
  input  tmg_cfg_t       cfg,
  output logic           sync_h_o,
  output logic           sync_v_o,
  output logic           de_o,
  output logic           sof_o
);
  logic [LW-1:0]  hb_end, ha_end;
  logic [VTW-1:0] vb_end, va_end;
  logic           hs_n, vs_n, de_n, sof_n;
  logic           hs_act_q, vs_act_q, de_act_q, sof_q;
  logic           hs_pol_q, vs_pol_q, de_pol_q;

  always_comb begin
    hb_end = LW'(cfg.h_sync) + LW'(cfg.h_back);
    ha_end = hb_end + LW'(cfg.h_act);
    vb_end = VTW'(cfg.v_sync) + VTW'(cfg.v_back);
    va_end = vb_end + VTW'(cfg.v_act);
    hs_n   = running && (hpos < BW'(cfg.h_sync));
    vs_n   = running && (vpos < VTW'(cfg.v_sync));
    de_n   = running && (hpos >= BW'(hb_end)) && (hpos < BW'(ha_end))
                     && (vpos >= vb_end) && (vpos < va_end);
    sof_n  = running && (hpos == BW'(hb_end)) && (vpos == vb_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_act_q <= 1'b0;
      vs_act_q <= 1'b0;
      de_act_q <= 1'b0;
      sof_q    <= 1'b0;
      hs_pol_q <= CFG_DEFAULT.hs_pol;
      vs_pol_q <= CFG_DEFAULT.vs_pol;
      de_pol_q <= CFG_DEFAULT.de_pol;
    end else begin
      hs_act_q <= hs_n;
      vs_act_q <= vs_n;
      de_act_q <= de_n;
      sof_q    <= sof_n;
      hs_pol_q <= cfg.hs_pol;
      vs_pol_q <= cfg.vs_pol;
      de_pol_q <= cfg.de_pol;
    end
  end

  assign sync_h_o = hs_act_q ? hs_pol_q : ~hs_pol_q;
  assign sync_v_o = vs_act_q ? vs_pol_q : ~vs_pol_q;
  assign de_o     = de_act_q ? de_pol_q : ~de_pol_q;
  assign sof_o    = sof_q;

  // R9
  sof_on_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> de_act_q);

  // R9
  sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |=> !sof_q);

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !(hs_act_q || vs_act_q || de_act_q || sof_q));
endmodule

// File: rtl/vtg_limiter_top.sv
module vtg_limiter_top
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_h_sync,
  input  logic [HW-1:0] cfg_h_back,
  input  logic [HW-1:0] cfg_h_act,
  input  logic [HW-1:0] cfg_h_front,
  input  logic [VW-1:0] cfg_v_sync,
  input  logic [VW-1:0] cfg_v_back,
  input  logic [VW-1:0] cfg_v_act,
  input  logic [VW-1:0] cfg_v_front,
  input  logic          cfg_hs_pol,
  input  logic          cfg_vs_pol,
  input  logic          cfg_de_pol,
  input  logic [BW-1:0] cfg_budget,
  output logic          sync_h_o,
  output logic          sync_v_o,
  output logic          de_o,
  output logic          sof_o
);
  tmg_cfg_t       cfg_d, cfg_q;
  logic [LW-1:0]  htot;
  logic [VTW-1:0] vtot;
  logic [BW-1:0]  ext;
  logic           running, load;
  logic [BW-1:0]  hpos;
  logic [VTW-1:0] vpos;

  always_comb begin
    cfg_d.h_sync  = cfg_h_sync;
    cfg_d.h_back  = cfg_h_back;
    cfg_d.h_act   = cfg_h_act;
    cfg_d.h_front = cfg_h_front;
    cfg_d.v_sync  = cfg_v_sync;
    cfg_d.v_back  = cfg_v_back;
    cfg_d.v_act   = cfg_v_act;
    cfg_d.v_front = cfg_v_front;
    cfg_d.hs_pol  = cfg_hs_pol;
    cfg_d.vs_pol  = cfg_vs_pol;
    cfg_d.de_pol  = cfg_de_pol;
    cfg_d.budget  = cfg_budget;
  end

  vtg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_d(cfg_d),
    .cfg_q(cfg_q), .htot(htot), .vtot(vtot), .ext(ext)
  );

  vtg_scan u_scan (
    .clk(clk), .rst_n(rst_n), .htot(htot), .vtot(vtot), .ext(ext),
    .running(running), .hpos(hpos), .vpos(vpos), .load(load)
  );

  vtg_decode u_decode (
    .clk(clk), .rst_n(rst_n), .running(running), .hpos(hpos), .vpos(vpos),
    .cfg(cfg_q), .sync_h_o(sync_h_o), .sync_v_o(sync_v_o), .de_o(de_o), .sof_o(sof_o)
  );
endmodule

// File: tb/sim_vtg_limiter_top.sv
`timescale 1ns/1ps
module sim_vtg_limiter_top;
  import vtg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] h_sync, h_back, h_act, h_front;
  logic [VW-1:0] v_sync, v_back, v_act, v_front;
  logic hs_pol, vs_pol, de_pol;
  logic [BW-1:0] budget;
  logic sync_h_o, sync_v_o, de_o, sof_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vtg_limiter_top u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_sync(h_sync), .cfg_h_back(h_back), .cfg_h_act(h_act), .cfg_h_front(h_front),
    .cfg_v_sync(v_sync), .cfg_v_back(v_back), .cfg_v_act(v_act), .cfg_v_front(v_front),
    .cfg_hs_pol(hs_pol), .cfg_vs_pol(vs_pol), .cfg_de_pol(de_pol), .cfg_budget(budget),
    .sync_h_o(sync_h_o), .sync_v_o(sync_v_o), .de_o(de_o), .sof_o(sof_o)
  );

  // hsync hback hact hfront vsync vback vact vfront hpol vpol depol budget expected_period
  localparam int NV = 5;
  localparam int VEC [NV][13] = '{
    '{4, 3,  8, 2, 2, 2, 4, 2, 0, 0, 1, 200, 200},
    '{2, 5,  6, 3, 1, 3, 5, 1, 1, 1, 1, 160, 160},
    '{3, 2, 10, 4, 3, 1, 3, 2, 1, 0, 0,  50, 171},
    '{1, 1,  5, 1, 1, 1, 3, 1, 0, 1, 1, 301, 301},
    '{6, 4, 12, 5, 2, 3, 6, 3, 0, 0, 1, 400, 400}
  };

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic apply(input int i);
    h_sync = HW'(VEC[i][0]); h_back = HW'(VEC[i][1]);
    h_act  = HW'(VEC[i][2]); h_front = HW'(VEC[i][3]);
    v_sync = VW'(VEC[i][4]); v_back = VW'(VEC[i][5]);
    v_act  = VW'(VEC[i][6]); v_front = VW'(VEC[i][7]);
    hs_pol = VEC[i][8][0]; vs_pol = VEC[i][9][0]; de_pol = VEC[i][10][0];
    budget = BW'(VEC[i][11]);
  endtask

  function automatic int htot_of(input int i);
    return VEC[i][0] + VEC[i][1] + VEC[i][2] + VEC[i][3];
  endfunction
  function automatic int vtot_of(input int i);
    return VEC[i][4] + VEC[i][5] + VEC[i][6] + VEC[i][7];
  endfunction
  function automatic int sof_off(input int i);
    return (VEC[i][4] + VEC[i][5]) * htot_of(i) + VEC[i][0] + VEC[i][1];
  endfunction

  // Count falling edges until sof is seen; returns -1 on timeout.
  task automatic to_sof(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (sof_o) break;
      if (n > 5000) begin n = -1; break; end
    end
  endtask

  // Called on the falling edge where sof was sampled; measures one whole frame.
  task automatic measure(input int i);
    int idx, per, de_cnt, hs_cnt, vs_cnt, hrise, hmin, hmax, de_lines, de_run, de_rmax;
    int last_hrise, last_hfall, gap_bad, ext;
    bit hs_a, vs_a, de_a, prev_hs, prev_de;
    hs_a = (sync_h_o == VEC[i][8][0]);
    vs_a = (sync_v_o == VEC[i][9][0]);
    de_a = (de_o == VEC[i][10][0]);
    // R4: at the first active pixel both syncs are idle and enable asserted
    chk("R4", "hsync level at sof", sync_h_o, !VEC[i][8][0]);
    chk("R4", "vsync level at sof", sync_v_o, !VEC[i][9][0]);
    chk("R4", "de level at sof", de_o, VEC[i][10][0]);
    chk("R9", "de asserted with sof", de_a, 1);
    de_cnt = de_a; hs_cnt = hs_a; vs_cnt = vs_a;
    de_run = de_a; de_rmax = de_a; de_lines = 1;
    hrise = 0; hmin = 1 << 30; hmax = 0; gap_bad = 0;
    last_hrise = -1; last_hfall = -1;
    prev_hs = hs_a; prev_de = 1'b1;
    idx = 0;
    forever begin
      @(negedge clk);
      idx++;
      if (sof_o || idx > 5000) break;
      hs_a = (sync_h_o == VEC[i][8][0]);
      vs_a = (sync_v_o == VEC[i][9][0]);
      de_a = (de_o == VEC[i][10][0]);
      hs_cnt += hs_a; vs_cnt += vs_a; de_cnt += de_a;
      if (hs_a && !prev_hs) begin
        hrise++;
        if (last_hrise >= 0) begin
          if (idx - last_hrise < hmin) hmin = idx - last_hrise;
          if (idx - last_hrise > hmax) hmax = idx - last_hrise;
        end
        last_hrise = idx;
      end
      if (!hs_a && prev_hs) last_hfall = idx;
      if (de_a && !prev_de) begin
        de_lines++;
        de_run = 0;
        if (last_hfall >= 0 && idx - last_hfall != VEC[i][1]) gap_bad++;
      end
      if (de_a) begin
        de_run++;
        if (de_run > de_rmax) de_rmax = de_run;
      end
      prev_hs = hs_a; prev_de = de_a;
    end
    per = idx;
    ext = VEC[i][12] - htot_of(i) * vtot_of(i);
    if (VEC[i][11] > htot_of(i) * vtot_of(i))
      chk("R5", "frame period to budget", per, VEC[i][12]);
    else
      chk("R6", "frame period clamped to nominal", per, VEC[i][12]);
    chk("R2", "hsync clocks per frame", hs_cnt, VEC[i][0] * vtot_of(i));
    chk("R2", "de run length", de_rmax, VEC[i][2]);
    chk("R2", "hsync-to-de gap errors", gap_bad, 0);
    chk("R3", "vsync clocks per frame", vs_cnt, VEC[i][4] * htot_of(i));
    chk("R3", "de lines per frame", de_lines, VEC[i][6]);
    chk("R3", "de clocks per frame", de_cnt, VEC[i][2] * VEC[i][6]);
    chk("R7", "hsync pulses per frame", hrise, vtot_of(i));
    chk("R7", "shortest line", hmin, htot_of(i));
    chk("R7", "longest line", hmax, htot_of(i) + ext);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    apply(0);
    repeat (3) @(negedge clk);
    // R1: idle levels under reset with default polarities
    chk("R1", "hsync in reset", sync_h_o, 1);
    chk("R1", "vsync in reset", sync_v_o, 1);
    chk("R1", "de in reset", de_o, 0);
    chk("R1", "sof in reset", sof_o, 0);
    rst_n = 1'b1;
    to_sof(n);
    chk("R10", "first sof after release", n, sof_off(0) + 2);

    // Vector loop: full frame per entry, then a mid-frame switch to the next.
    for (int i = 0; i < NV; i++) begin
      measure(i);
      if (i < NV - 1) begin
        apply(i + 1);
        to_sof(n);
        // R8: current frame finishes on old settings, next starts on new
        chk("R8", "mixed interval after mid-frame change", n,
            VEC[i][12] - sof_off(i) + sof_off(i + 1));
        to_sof(n);
      end
    end

    // Directed: reset in the middle of a frame returns to idle defaults.
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "hsync after mid-run reset", sync_h_o, 1);
    chk("R1", "vsync after mid-run reset", sync_v_o, 1);
    chk("R1", "de after mid-run reset", de_o, 0);
    chk("R1", "sof after mid-run reset", sof_o, 0);
    @(negedge clk);
    apply(3);
    rst_n = 1'b1;
    to_sof(n);
    chk("R10", "first sof after second release", n, sof_off(3) + 2);
    measure(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule